// File: doc/BRIEF.md
# CAN Receive Acceptance Router

This block sits after a CAN bit-stream receiver. When a frame has been fully received, the receiver presents the identifier, the frame-type bits, the length code and the payload for one cycle. The router compares the identifier against six programmable acceptance filters under two programmable masks. From the result it decides whether the frame is kept and, if so, which of two receive buffers gets it.

Filters 0 and 1 work under mask 0 and feed buffer 0. Filters 2 to 5 work under mask 1 and feed buffer 1. Buffer 0 can be allowed to spill into buffer 1 while it is still occupied. Each buffer has a full flag that the router sets and the host clears, and an overflow flag that records a frame lost because its destination was occupied. The load port carries a registered copy of the accepted frame, the chosen buffer and the number of the filter that matched.

Top module: `can_rx_router`

## Requirements
- R1: Each filter and mask is a 32-bit word. Bits 31:24 hold SID[10:3]. Bits 23:21 hold SID[2:0]. Bit 19 is the extended-enable bit (filters only). Bits 17:16 hold EID[17:16] and bits 15:0 hold EID[15:0]. Filter n occupies `flt_cfg[32n+31:32n]`, mask 0 occupies `msk_cfg[31:0]` and mask 1 occupies `msk_cfg[63:32]`.
- R2: A mask bit of 1 requires the filter bit to equal the identifier bit, and a mask bit of 0 makes that bit don't-care. A standard frame is compared on its 11 SID bits only. An extended frame is compared on all 29 bits.
- R3: A filter can match only a frame whose IDE equals the filter's extended-enable bit.
- R4: Filters 0 and 1 are compared under mask 0 and route to buffer 0 (`ld_buf`=0). Filters 2 to 5 are compared under mask 1 and route to buffer 1 (`ld_buf`=1).
- R5: When a frame is wanted by both buffers, buffer 0 takes it. Within a group, the lowest-numbered matching filter is the one reported.
- R6: `ld_hit` gives the filter number. For buffer 0 it is 0 or 1. For buffer 1 it is 2 to 5, or 0 or 1 only for a rolled-over frame.
- R7: With `b0_roll`=1, a frame wanted by buffer 0 while buffer 0 is full is loaded into buffer 1, keeping its filter number 0 or 1.
- R8: Receive mode 2'b11 makes a buffer accept every frame. If no filter of its group matched, the reported hit is the group's lowest filter (0 or 2). Mode 2'b00 (and the unused codes) accepts only frames that match a filter of the group. A frame that no buffer wants produces no load and changes no flag.
- R9: A load sets the target buffer's bit in `buf_full` (bit 0 for buffer 0, bit 1 for buffer 1). A pulse on the matching `full_clr` bit clears it. A load wins over a clear in the same cycle.
- R10: An accepted frame whose target buffer is full is dropped and sets that buffer's `buf_ovf` bit. With rollover the target is buffer 1. Without rollover a frame wanted by buffer 0 sets bit 0, even if buffer 1 is empty. `ovf_clr` clears the bit.
- R11: `ld_valid` pulses in the cycle after the `frm_valid` cycle. In that cycle, `ld_sid`, `ld_eid`, `ld_ide`, `ld_rtr`, `ld_dlc` and `ld_data` equal the frame's fields.
- R12: After reset, `ld_valid`, `buf_full` and `buf_ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe: a received frame is presented |
| frm_sid | input | 11 | Standard identifier bits |
| frm_eid | input | 18 | Extended identifier bits (used when frm_ide=1) |
| frm_ide | input | 1 | 1 = extended frame |
| frm_rtr | input | 1 | Remote request flag of the frame |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 64 | Payload bytes |
| flt_cfg | input | 192 | Six filter words, R1 layout |
| msk_cfg | input | 64 | Two mask words, R1 layout |
| b0_mode | input | 2 | Receive mode of buffer 0 |
| b0_roll | input | 1 | Rollover enable from buffer 0 to buffer 1 |
| b1_mode | input | 2 | Receive mode of buffer 1 |
| full_clr | input | 2 | Host clear of the full flags |
| ovf_clr | input | 2 | Host clear of the overflow flags |
| ld_valid | output | 1 | Buffer-load strobe |
| ld_buf | output | 1 | Selected buffer |
| ld_hit | output | 3 | Number of the filter that accepted the frame |
| ld_sid | output | 11 | Loaded standard identifier |
| ld_eid | output | 18 | Loaded extended identifier |
| ld_ide | output | 1 | Loaded IDE flag |
| ld_rtr | output | 1 | Loaded RTR flag |
| ld_dlc | output | 4 | Loaded length code |
| ld_data | output | 64 | Loaded payload |
| buf_full | output | 2 | Full flags, bit n for buffer n |
| buf_ovf | output | 2 | Overflow flags, bit n for buffer n |

## Verification
The hardest case to reach is the rollover path with both buffers occupied. Three conditions must hold at once: buffer 0 must be full, buffer 1 must be full, and the frame must match a buffer-0 filter. Only then is overflow charged to buffer 1, not buffer 0. The stimulus builds this state step by step. It loads buffer 0 without clearing it, sends a second buffer-0 frame that rolls over and fills buffer 1, and only then sends a third one. Overlapping filter matches under a relaxed mask are created by zeroing low mask bits. This makes one identifier hit three filters at once, which exercises the lowest-filter rule.

// File: rtl/can_rxr_pkg.sv
// Shared constants and field extraction for the acceptance router.
// Assumes the 32-bit filter/mask word layout given in the brief (R1).
package can_rxr_pkg;

    localparam int SID_W = 11;
    localparam int EID_W = 18;
    localparam int CFG_W = 32;

    localparam logic [1:0] MODE_ANY = 2'b11;

    // Standard identifier portion of a configuration word.
    function automatic logic [SID_W-1:0] cfg_sid(input logic [CFG_W-1:0] w);
        return {w[31:24], w[23:21]};
    endfunction

    // Extended identifier portion of a configuration word.
    function automatic logic [EID_W-1:0] cfg_eid(input logic [CFG_W-1:0] w);
        return {w[17:16], w[15:0]};
    endfunction

    // Extended-enable bit of a filter word.
    function automatic logic cfg_ext(input logic [CFG_W-1:0] w);
        return w[19];
    endfunction

endpackage

// File: rtl/can_rxr_filter.sv
// One acceptance comparator: masked identifier compare plus IDE qualification.
// Assumes the mask word uses the same layout as the filter word; its
// extended-enable and spare bits carry no meaning.
module can_rxr_filter
    import can_rxr_pkg::*;
(
    input  logic [CFG_W-1:0] flt_word,
    input  logic [CFG_W-1:0] msk_word,
    input  logic [SID_W-1:0] sid,
    input  logic [EID_W-1:0] eid,
    input  logic             ide,
    output logic             hit
);
    logic sid_ok;
    logic eid_ok;
    logic unused_cfg_bits;

    // Compare identifier bits selected by the mask; extended bits only for extended frames.
    always_comb begin
        sid_ok = ((sid ^ cfg_sid(flt_word)) & cfg_sid(msk_word)) == '0;
        eid_ok = ((eid ^ cfg_eid(flt_word)) & cfg_eid(msk_word)) == '0;
        hit    = (ide == cfg_ext(flt_word)) && sid_ok && (!ide || eid_ok);
    end

    assign unused_cfg_bits = ^{msk_word[20:18], flt_word[20], flt_word[18]};

endmodule

// File: rtl/can_rxr_prio.sv
// Priority encoder for one filter group: lowest-numbered hit wins.
// Assumes BASE is the number of the group's first filter; with no hit the
// code defaults to BASE so that accept-any mode reports a stable value.
module can_rxr_prio #(
    parameter int N    = 2,
    parameter int BASE = 0,
    parameter int CW   = 3
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [CW-1:0] code
);
    // Scan from the top so the lowest matching index is the last one written.
    always_comb begin
        any  = |hits;
        code = CW'(BASE);
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) code = CW'(BASE + i);
        end
    end

endmodule

// File: rtl/can_rxr_bufflag.sv
// Full and overflow flags of one receive buffer.
// Assumes set and clear strobes are one cycle wide; a set wins over a clear.
module can_rxr_bufflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_full,
    input  logic clr_full,
    input  logic set_ovf,
    input  logic clr_ovf,
    output logic full,
    output logic ovf
);
    // Full flag: set by a load, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)        full <= 1'b0;
        else if (set_full) full <= 1'b1;
        else if (clr_full) full <= 1'b0;
    end

    // Overflow flag: set by a dropped frame, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (set_ovf) ovf <= 1'b1;
        else if (clr_ovf) ovf <= 1'b0;
    end

endmodule

// File: rtl/can_rx_router.sv
// Acceptance router: compares a completed frame against the filter bank,
// chooses buffer 0, buffer 1 (directly or by rollover) or none, and
// maintains per-buffer full/overflow flags.
// Assumes frm_valid is a single-cycle strobe and configuration is static
// while a frame is presented. Result appears one cycle after the strobe.
module can_rx_router
    import can_rxr_pkg::*;
#(
    parameter int NUM_FLT    = 6,
    parameter int G0_FLT     = 2,
    parameter int DATA_BYTES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frm_valid,
    input  logic [10:0]               frm_sid,
    input  logic [17:0]               frm_eid,
    input  logic                      frm_ide,
    input  logic                      frm_rtr,
    input  logic [3:0]                frm_dlc,
    input  logic [8*DATA_BYTES-1:0]   frm_data,
    input  logic [NUM_FLT*32-1:0]     flt_cfg,
    input  logic [63:0]               msk_cfg,
    input  logic [1:0]                b0_mode,
    input  logic                      b0_roll,
    input  logic [1:0]                b1_mode,
    input  logic [1:0]                full_clr,
    input  logic [1:0]                ovf_clr,
    output logic                      ld_valid,
    output logic                      ld_buf,
    output logic [$clog2(NUM_FLT)-1:0] ld_hit,
    output logic [10:0]               ld_sid,
    output logic [17:0]               ld_eid,
    output logic                      ld_ide,
    output logic                      ld_rtr,
    output logic [3:0]                ld_dlc,
    output logic [8*DATA_BYTES-1:0]   ld_data,
    output logic [1:0]                buf_full,
    output logic [1:0]                buf_ovf
);
    localparam int G1_FLT = NUM_FLT - G0_FLT;
    localparam int HIT_W  = $clog2(NUM_FLT);

    logic [NUM_FLT-1:0] hits;
    logic               any0, any1;
    logic [HIT_W-1:0]   code0, code1;
    logic               want0, want1;
    logic               do_load;
    logic               tgt;
    logic [HIT_W-1:0]   tgt_code;
    logic [1:0]         set_full;
    logic [1:0]         set_ovf;

    // Filter bank: first group under mask 0, the rest under mask 1.
    for (genvar i = 0; i < NUM_FLT; i++) begin : g_flt
        if (i < G0_FLT) begin : g_m0
            can_rxr_filter u_flt (
                .flt_word (flt_cfg[32*i +: 32]),
                .msk_word (msk_cfg[31:0]),
                .sid      (frm_sid),
                .eid      (frm_eid),
                .ide      (frm_ide),
                .hit      (hits[i])
            );
        end else begin : g_m1
            can_rxr_filter u_flt (
                .flt_word (flt_cfg[32*i +: 32]),
                .msk_word (msk_cfg[63:32]),
                .sid      (frm_sid),
                .eid      (frm_eid),
                .ide      (frm_ide),
                .hit      (hits[i])
            );
        end
    end

    can_rxr_prio #(.N(G0_FLT), .BASE(0), .CW(HIT_W)) u_prio0 (
        .hits (hits[G0_FLT-1:0]),
        .any  (any0),
        .code (code0)
    );

    can_rxr_prio #(.N(G1_FLT), .BASE(G0_FLT), .CW(HIT_W)) u_prio1 (
        .hits (hits[NUM_FLT-1:G0_FLT]),
        .any  (any1),
        .code (code1)
    );

    // Routing decision: buffer 0 first, rollover next, buffer 1 last.
    always_comb begin
        want0    = (b0_mode == MODE_ANY) || any0;
        want1    = (b1_mode == MODE_ANY) || any1;
        do_load  = 1'b0;
        tgt      = 1'b0;
        tgt_code = code0;
        set_ovf  = 2'b00;
        if (frm_valid) begin
            if (want0) begin
                if (!buf_full[0]) begin
                    do_load = 1'b1;
                end else if (b0_roll) begin
                    tgt = 1'b1;
                    if (!buf_full[1]) do_load    = 1'b1;
                    else              set_ovf[1] = 1'b1;
                end else begin
                    set_ovf[0] = 1'b1;
                end
            end else if (want1) begin
                tgt      = 1'b1;
                tgt_code = code1;
                if (!buf_full[1]) do_load    = 1'b1;
                else              set_ovf[1] = 1'b1;
            end
        end
        set_full[0] = do_load && !tgt;
        set_full[1] = do_load && tgt;
    end

    // Load port: one-cycle strobe with a registered copy of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_buf   <= 1'b0;
            ld_hit   <= '0;
            ld_sid   <= '0;
            ld_eid   <= '0;
            ld_ide   <= 1'b0;
            ld_rtr   <= 1'b0;
            ld_dlc   <= '0;
            ld_data  <= '0;
        end else begin
            ld_valid <= do_load;
            if (do_load) begin
                ld_buf  <= tgt;
                ld_hit  <= tgt_code;
                ld_sid  <= frm_sid;
                ld_eid  <= frm_eid;
                ld_ide  <= frm_ide;
                ld_rtr  <= frm_rtr;
                ld_dlc  <= frm_dlc;
                ld_data <= frm_data;
            end
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_buf
        can_rxr_bufflag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_full (set_full[b]),
            .clr_full (full_clr[b]),
            .set_ovf  (set_ovf[b]),
            .clr_ovf  (ovf_clr[b]),
            .full     (buf_full[b]),
            .ovf      (buf_ovf[b])
        );
    end

endmodule

// File: rtl/can_rx_router_chk.sv
// Property checker for can_rx_router, bound to every instance.
// Assumes the default two-buffer arrangement with filters 0 and 1 in group 0.
module can_rx_router_chk #(
    parameter int NUM_FLT = 6,
    parameter int HIT_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_valid,
    input logic             b0_roll,
    input logic             ld_valid,
    input logic             ld_buf,
    input logic [HIT_W-1:0] ld_hit,
    input logic [1:0]       buf_full,
    input logic [1:0]       buf_ovf
);
    p_load_follows_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(frm_valid));

    p_load_sets_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> buf_full[ld_buf]);

    p_b0_hit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_buf) |-> (ld_hit < HIT_W'(2)));

    p_hit_in_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> (ld_hit < HIT_W'(NUM_FLT)));

    p_low_code_needs_roll_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_buf && ld_hit < HIT_W'(2)) |-> $past(b0_roll));

    p_no_overflow_b0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_ovf[0]) |-> (!ld_valid && $past(buf_full[0])));

    p_no_overflow_b1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_ovf[1]) |-> (!ld_valid && $past(buf_full[1])));

endmodule

bind can_rx_router can_rx_router_chk #(.NUM_FLT(NUM_FLT), .HIT_W(HIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .b0_roll   (b0_roll),
    .ld_valid  (ld_valid),
    .ld_buf    (ld_buf),
    .ld_hit    (ld_hit),
    .buf_full  (buf_full),
    .buf_ovf   (buf_ovf)
);

// File: tb/tb_can_rx_router.sv
// Directed bench for can_rx_router: one task per scenario.
module tb_can_rx_router;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frm_valid = 1'b0;
    logic [10:0]  frm_sid = '0;
    logic [17:0]  frm_eid = '0;
    logic         frm_ide = 1'b0;
    logic         frm_rtr = 1'b0;
    logic [3:0]   frm_dlc = '0;
    logic [63:0]  frm_data = '0;
    logic [191:0] flt_cfg = '0;
    logic [63:0]  msk_cfg = '0;
    logic [1:0]   b0_mode = 2'b00;
    logic         b0_roll = 1'b0;
    logic [1:0]   b1_mode = 2'b00;
    logic [1:0]   full_clr = 2'b00;
    logic [1:0]   ovf_clr = 2'b00;
    logic         ld_valid, ld_buf, ld_ide, ld_rtr;
    logic [2:0]   ld_hit;
    logic [10:0]  ld_sid;
    logic [17:0]  ld_eid;
    logic [3:0]   ld_dlc;
    logic [63:0]  ld_data;
    logic [1:0]   buf_full, buf_ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_rx_router dut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_sid(frm_sid),
        .frm_eid(frm_eid), .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
        .frm_data(frm_data), .flt_cfg(flt_cfg), .msk_cfg(msk_cfg), .b0_mode(b0_mode),
        .b0_roll(b0_roll), .b1_mode(b1_mode), .full_clr(full_clr), .ovf_clr(ovf_clr),
        .ld_valid(ld_valid), .ld_buf(ld_buf), .ld_hit(ld_hit), .ld_sid(ld_sid),
        .ld_eid(ld_eid), .ld_ide(ld_ide), .ld_rtr(ld_rtr), .ld_dlc(ld_dlc),
        .ld_data(ld_data), .buf_full(buf_full), .buf_ovf(buf_ovf)
    );

    // Configuration word in the R1 layout.
    function automatic logic [31:0] cfgw(input logic [10:0] sid, input logic [17:0] eid,
                                         input logic ext);
        return {sid[10:3], sid[2:0], 1'b0, ext, 1'b0, eid[17:16], eid[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present a frame for one cycle; returns at the following falling edge.
    task automatic send(input logic [10:0] sid, input logic [17:0] eid, input logic ide,
                        input logic [3:0] dlc, input logic [63:0] data);
        frm_sid = sid; frm_eid = eid; frm_ide = ide; frm_dlc = dlc; frm_data = data;
        frm_rtr = dlc[0];
        frm_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic expect_load(input string tag, input logic b, input logic [2:0] h);
        chk({tag, " ld_valid"}, 64'(ld_valid), 64'd1);
        chk({tag, " ld_buf"},   64'(ld_buf),   64'(b));
        chk({tag, " ld_hit"},   64'(ld_hit),   64'(h));
    endtask

    task automatic expect_none(input string tag);
        chk({tag, " no load"}, 64'(ld_valid), 64'd0);
    endtask

    task automatic clear_flags();
        full_clr = 2'b11; ovf_clr = 2'b11;
        @(posedge clk);
        @(negedge clk);
        full_clr = 2'b00; ovf_clr = 2'b00;
    endtask

    task automatic default_cfg();
        msk_cfg = {cfgw(11'h7FF, 18'h3FFFF, 1'b0), cfgw(11'h7FF, 18'h3FFFF, 1'b0)};
        flt_cfg = {cfgw(11'h202, 18'h0, 1'b0),     // filter 5
                   cfgw(11'h48D, 18'h24567, 1'b1), // filter 4 (extended)
                   cfgw(11'h201, 18'h0, 1'b0),     // filter 3
                   cfgw(11'h200, 18'h0, 1'b0),     // filter 2
                   cfgw(11'h101, 18'h0, 1'b0),     // filter 1
                   cfgw(11'h100, 18'h0, 1'b0)};    // filter 0
        b0_mode = 2'b00; b1_mode = 2'b00; b0_roll = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 ld_valid", 64'(ld_valid), 64'd0);
        chk("R12 buf_full", 64'(buf_full), 64'd0);
        chk("R12 buf_ovf",  64'(buf_ovf),  64'd0);
    endtask

    task automatic t_group0();
        send(11'h100, 18'h0, 1'b0, 4'd8, 64'h1122334455667788);
        expect_load("R4 f0", 1'b0, 3'd0);
        chk("R11 sid",  64'(ld_sid),  64'h100);
        chk("R11 dlc",  64'(ld_dlc),  64'd8);
        chk("R11 data", ld_data, 64'h1122334455667788);
        chk("R11 rtr",  64'(ld_rtr),  64'd0);
        chk("R9 full0 set", 64'(buf_full), 64'b01);
        clear_flags();
        chk("R9 full0 cleared", 64'(buf_full), 64'b00);
        send(11'h101, 18'h0, 1'b0, 4'd3, 64'hAB);
        expect_load("R4 f1", 1'b0, 3'd1);
        chk("R11 rtr copy", 64'(ld_rtr), 64'd1);
        clear_flags();
    endtask

    task automatic t_group1();
        send(11'h200, 18'h3ABCD, 1'b0, 4'd1, 64'h5);
        expect_load("R2 f2 std ignores eid", 1'b1, 3'd2);
        chk("R9 full1 set", 64'(buf_full), 64'b10);
        clear_flags();
        send(11'h201, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_load("R4 f3", 1'b1, 3'd3);
        clear_flags();
        send(11'h48D, 18'h24567, 1'b1, 4'd2, 64'h77);
        expect_load("R4 f4 ext", 1'b1, 3'd4);
        chk("R11 eid", 64'(ld_eid), 64'h24567);
        chk("R11 ide", 64'(ld_ide), 64'd1);
        clear_flags();
        send(11'h202, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_load("R4 f5", 1'b1, 3'd5);
        clear_flags();
    endtask

    task automatic t_ide_and_eid();
        send(11'h48D, 18'h24567, 1'b0, 4'd0, 64'h0);
        expect_none("R3 std vs ext filter");
        send(11'h100, 18'h00001, 1'b1, 4'd0, 64'h0);
        expect_none("R3 ext vs std filter");
        send(11'h48D, 18'h24568, 1'b1, 4'd0, 64'h0);
        expect_none("R2 ext eid mismatch");
        chk("R8 flags untouched", 64'({buf_full, buf_ovf}), 64'd0);
    endtask

    task automatic t_mask();
        msk_cfg[63:32] = cfgw(11'h7FC, 18'h3FFFF, 1'b0);
        send(11'h203, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_load("R5 lowest of f2/f3/f5", 1'b1, 3'd2);
        clear_flags();
        msk_cfg[63:32] = cfgw(11'h7FF, 18'h3FFFF, 1'b0);
        send(11'h203, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_none("R2 full mask rejects");
    endtask

    task automatic t_modes();
        b1_mode = 2'b11;
        send(11'h100, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_load("R5 buffer0 priority", 1'b0, 3'd0);
        clear_flags();
        send(11'h555, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_load("R8 any mode b1", 1'b1, 3'd2);
        clear_flags();
        b1_mode = 2'b00; b0_mode = 2'b11;
        send(11'h555, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_load("R8 any mode b0", 1'b0, 3'd0);
        clear_flags();
        send(11'h200, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_load("R5 any b0 over f2", 1'b0, 3'd0);
        clear_flags();
        b0_mode = 2'b00;
        send(11'h555, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_none("R8 reject");
    endtask

    task automatic t_rollover();
        b0_roll = 1'b1;
        send(11'h100, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_load("R7 first to b0", 1'b0, 3'd0);
        send(11'h101, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_load("R7 rolled to b1", 1'b1, 3'd1);
        chk("R7 both full", 64'(buf_full), 64'b11);
        send(11'h100, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_none("R10 roll both full");
        chk("R10 ovf on b1", 64'(buf_ovf), 64'b10);
        clear_flags();
        chk("R10 ovf cleared", 64'(buf_ovf), 64'b00);
        b0_roll = 1'b0;
    endtask

    task automatic t_overflow();
        send(11'h101, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_load("R9 fill b0", 1'b0, 3'd1);
        send(11'h100, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_none("R10 b0 full drop");
        chk("R10 ovf0 set", 64'(buf_ovf), 64'b01);
        chk("R10 b1 stays empty", 64'(buf_full), 64'b01);
        clear_flags();
        send(11'h200, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_load("R9 fill b1", 1'b1, 3'd2);
        send(11'h201, 18'h0, 1'b0, 4'd0, 64'h0);
        expect_none("R10 b1 full drop");
        chk("R10 ovf1 set", 64'(buf_ovf), 64'b10);
        clear_flags();
    endtask

    initial begin : main
        default_cfg();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_group0();
        t_group1();
        t_ide_and_eid();
        t_mask();
        t_modes();
        t_rollover();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule